// File: doc/BRIEF.md
# Relative-Addressed Floating-Point Register Stack

This block holds the working registers of a floating-point unit as an eight-entry circular stack. Every register is named by its distance from a moving top pointer, so st(0) is the current top and st(i) is the entry i places below it. A three-bit operation code, presented once per cycle, selects one of these actions:

- push a loaded value
- pop the top
- write a result back to the top or to st(i)
- exchange the top with st(i)
- write a result to st(1) and pop in the same cycle
- check the operands of a dyadic operation

Two combinational operand ports feed the arithmetic units. Port A always shows st(0). Port B shows st(1) for the implicit form, or st(i) when the accumulator form is selected. Each entry is 80 bits wide, which is enough for a 64-bit mantissa plus exponent and sign. Each entry also carries a tag that marks it empty or valid. The block flags pushes onto a valid entry as overflow, and uses of empty entries as underflow. A faulting operation leaves the stack unchanged. The asynchronous reset is released synchronously inside the block, so the stack leaves reset two clock edges after the reset input rises.

Top module: `stk_file`

## Requirements
- R1: After reset the top pointer is 0 and all eight entries are empty, so a pop or an operand check raises underflow.
- R2: Port B with bsel_i=1 shows st(idx_i), the entry at physical index (top + idx_i) mod 8, and idx_i=0 gives st(0).
- R3: Push (op 1) onto an empty slot moves the top to (top - 1) mod 8 and stores wdata_i there as the new st(0).
- R4: Pop (op 2) of a valid st(0) moves the top to (top + 1) mod 8 and marks the old top entry empty.
- R5: Push onto a valid entry raises ovf_o in that cycle and changes neither the top pointer nor any entry. ovf_o is raised by no other operation.
- R6: Pop, exchange, write-and-pop or operand check (op 7) that needs an empty entry raises unf_o in that cycle and changes nothing. Op 7 needs st(0) and the port B entry.
- R7: With bsel_i=0, port A shows st(0) and port B shows st(1), which are the implicit operands of a dyadic operation.
- R8: Write-top (op 3) stores wdata_i into st(0), and write-index (op 4) stores it into st(idx_i). Neither moves the top.
- R9: Exchange (op 5) swaps the contents of st(0) and st(idx_i) when both are valid.
- R10: Write-and-pop (op 6) stores wdata_i into st(1) and pops in one cycle, so that value becomes the new st(0).
- R11: The top pointer wraps modulo 8, so the first push after reset leaves the top at 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | 0 none, 1 push, 2 pop, 3 write top, 4 write index, 5 exchange, 6 write-and-pop, 7 operand check |
| idx_i | input | 3 | Relative register index i |
| bsel_i | input | 1 | 1: port B shows st(idx_i); 0: port B shows st(1) |
| wdata_i | input | 80 | Value for push and write operations |
| opa_o | output | 80 | Contents of st(0) |
| opb_o | output | 80 | Contents of st(1) or st(idx_i) |
| top_o | output | 3 | Physical index of the current top |
| ovf_o | output | 1 | Overflow for the presented operation |
| unf_o | output | 1 | Underflow for the presented operation |

## Verification
The stack is driven through several patterns:

- A short fill of three values tells relative addressing apart from physical addressing, because the top has already wrapped from 0 to 7.
- Reading port B in both the implicit form and the indexed form tells st(1) apart from st(i).
- An exchange, a write-back to the top, a write-back to st(i) and a write-and-pop, each followed by an idle cycle, show whether the written value reached the right relative slot.
- Faulting operations on a nearly empty stack, followed by an idle cycle, show that a fault leaves the pointer and the data untouched.
- A complete fill of eight values followed by a ninth push tells the overflow case apart from a full-but-legal stack, and reaching the oldest value through st(7) checks the deepest index.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_PUSH   = 3'd1,
    OP_POP    = 3'd2,
    OP_WR_TOP = 3'd3,
    OP_WR_IDX = 3'd4,
    OP_XCH    = 3'd5,
    OP_WR_POP = 3'd6,
    OP_CHECK  = 3'd7
  } stk_op_e;

  // read port slots of the storage array
  localparam int RD_TOP  = 0;
  localparam int RD_B    = 1;
  localparam int RD_IDX  = 2;
  localparam int RD_NUM  = 3;

endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/stk_top_ptr.sv
module stk_top_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             step_dn,
  output logic [PTR_W-1:0] top
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] top_q;
  logic [PTR_W-1:0] top_d;

  always_comb begin
    if (step_dn) begin
      top_d = top_q - ONE;
    end else begin
      top_d = top_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
    end else if (step_en) begin
      top_q <= top_d;
    end
  end

  assign top = top_q;

endmodule

// File: rtl/stk_tags.sv
module stk_tags #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [PTR_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [PTR_W-1:0] clr_idx,
  output logic [DEPTH-1:0] valid
);

  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] valid_d;
  logic             upd_en;

  for (genvar e = 0; e < DEPTH; e++) begin : g_tag
    localparam logic [PTR_W-1:0] ME = PTR_W'(e);
    always_comb begin
      valid_d[e] = valid_q[e];
      if (clr_en && (clr_idx == ME)) begin
        valid_d[e] = 1'b0;
      end
      if (set_en && (set_idx == ME)) begin
        valid_d[e] = 1'b1;
      end
    end
  end

  assign upd_en = set_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
    end
  end

  assign valid = valid_q;

endmodule

// File: rtl/stk_regs.sv
module stk_regs #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  parameter int PTR_W = 3,
  parameter int NRD   = 3
) (
  input  logic             clk,
  input  logic             we0,
  input  logic [PTR_W-1:0] wa0,
  input  logic [WIDTH-1:0] wd0,
  input  logic             we1,
  input  logic [PTR_W-1:0] wa1,
  input  logic [WIDTH-1:0] wd1,
  input  logic [PTR_W-1:0] ra [NRD],
  output logic [WIDTH-1:0] rd [NRD]
);

  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam logic [PTR_W-1:0] ME = PTR_W'(e);
    logic [WIDTH-1:0] ent_q;
    logic [WIDTH-1:0] ent_d;
    logic             ent_en;

    // port 0 wins when both ports address this entry
    always_comb begin
      ent_en = 1'b0;
      ent_d  = ent_q;
      if (we1 && (wa1 == ME)) begin
        ent_en = 1'b1;
        ent_d  = wd1;
      end
      if (we0 && (wa0 == ME)) begin
        ent_en = 1'b1;
        ent_d  = wd0;
      end
    end

    always_ff @(posedge clk) begin
      if (ent_en) begin
        ent_q <= ent_d;
      end
    end

    assign mem[e] = ent_q;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd[r] = mem[ra[r]];
  end

endmodule

// File: rtl/stk_file.sv
module stk_file #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [2:0]       op_i,
  input  logic [PTR_W-1:0] idx_i,
  input  logic             bsel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] opa_o,
  output logic [WIDTH-1:0] opb_o,
  output logic [PTR_W-1:0] top_o,
  output logic             ovf_o,
  output logic             unf_o
);

  import stk_pkg::*;

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic             rst_n;
  stk_op_e          op;
  logic [PTR_W-1:0] top;
  logic [PTR_W-1:0] p_top, p_one, p_idx, p_new, p_b;
  logic [DEPTH-1:0] valid;
  logic [PTR_W-1:0] ra [RD_NUM];
  logic [WIDTH-1:0] rd [RD_NUM];

  logic             step_en, step_dn;
  logic             set_en, clr_en;
  logic [PTR_W-1:0] set_idx, clr_idx;
  logic             we0, we1;
  logic [PTR_W-1:0] wa0, wa1;
  logic [WIDTH-1:0] wd0, wd1;
  logic             ovf, unf;

  stk_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  stk_top_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .step_dn (step_dn),
    .top     (top)
  );

  stk_tags #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_en),
    .set_idx (set_idx),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .valid   (valid)
  );

  stk_regs #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W), .NRD(RD_NUM)) u_regs (
    .clk (clk),
    .we0 (we0),
    .wa0 (wa0),
    .wd0 (wd0),
    .we1 (we1),
    .wa1 (wa1),
    .wd1 (wd1),
    .ra  (ra),
    .rd  (rd)
  );

  // relative to physical index translation
  assign op    = stk_op_e'(op_i);
  assign p_top = top;
  assign p_one = top + ONE;
  assign p_new = top - ONE;
  assign p_idx = top + idx_i;
  assign p_b   = bsel_i ? p_idx : p_one;

  assign ra[RD_TOP] = p_top;
  assign ra[RD_B]   = p_b;
  assign ra[RD_IDX] = p_idx;

  // fault detection for the presented operation
  always_comb begin
    ovf = 1'b0;
    unf = 1'b0;
    unique case (op)
      OP_PUSH:   ovf = valid[p_new];
      OP_POP:    unf = !valid[p_top];
      OP_XCH:    unf = !valid[p_top] || !valid[p_idx];
      OP_WR_POP: unf = !valid[p_top] || !valid[p_one];
      OP_CHECK:  unf = !valid[p_top] || !valid[p_b];
      default: begin
        ovf = 1'b0;
        unf = 1'b0;
      end
    endcase
  end

  // next-state decode: pointer, tags and write ports
  always_comb begin
    step_en = 1'b0;
    step_dn = 1'b0;
    set_en  = 1'b0;
    set_idx = p_top;
    clr_en  = 1'b0;
    clr_idx = p_top;
    we0     = 1'b0;
    wa0     = p_top;
    wd0     = wdata_i;
    we1     = 1'b0;
    wa1     = p_idx;
    wd1     = rd[RD_TOP];
    unique case (op)
      OP_PUSH: begin
        if (!ovf) begin
          step_en = 1'b1;
          step_dn = 1'b1;
          set_en  = 1'b1;
          set_idx = p_new;
          we0     = 1'b1;
          wa0     = p_new;
        end
      end
      OP_POP: begin
        if (!unf) begin
          step_en = 1'b1;
          clr_en  = 1'b1;
        end
      end
      OP_WR_TOP: begin
        set_en = 1'b1;
        we0    = 1'b1;
      end
      OP_WR_IDX: begin
        set_en  = 1'b1;
        set_idx = p_idx;
        we0     = 1'b1;
        wa0     = p_idx;
      end
      OP_XCH: begin
        if (!unf) begin
          we0 = 1'b1;
          wd0 = rd[RD_IDX];
          we1 = 1'b1;
        end
      end
      OP_WR_POP: begin
        if (!unf) begin
          step_en = 1'b1;
          clr_en  = 1'b1;
          we0     = 1'b1;
          wa0     = p_one;
        end
      end
      default: begin
        step_en = 1'b0;
      end
    endcase
  end

  assign opa_o = rd[RD_TOP];
  assign opb_o = rd[RD_B];
  assign top_o = top;
  assign ovf_o = ovf;
  assign unf_o = unf;

endmodule

// File: rtl/stk_file_chk.sv
module stk_file_chk #(
  parameter int WIDTH = 80,
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op,
  input logic             bsel,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [PTR_W-1:0] top,
  input logic             ovf,
  input logic             unf
);

  import stk_pkg::*;

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  always @(posedge clk) begin
    if (rst_n == 1'b0) begin
      AST_RESET_TOP: assert (top == '0); // R1
    end
  end

  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && !ovf) |=> (top == $past(top) - ONE)); // R3

  AST_PUSH_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH && !ovf) |=> (opa == $past(wdata))); // R3

  AST_POP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP && !unf) |=> (top == $past(top) + ONE)); // R4

  AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (op == OP_PUSH)); // R5

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf || unf) |=> $stable(top)); // R6

  AST_WRITE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WR_TOP) |=> (opa == $past(wdata))); // R8

  AST_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XCH && !unf && bsel) |=> (opa == $past(opb))); // R9

  AST_WRITE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WR_POP && !unf) |=> (opa == $past(wdata) && top == $past(top) + ONE)); // R10

endmodule

bind stk_file stk_file_chk #(.WIDTH(WIDTH), .PTR_W(PTR_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .op    (op_i),
  .bsel  (bsel_i),
  .wdata (wdata_i),
  .opa   (opa_o),
  .opb   (opb_o),
  .top   (top_o),
  .ovf   (ovf_o),
  .unf   (unf_o)
);

// File: tb/stk_file_test.sv
module stk_file_test;

  localparam logic [2:0] NOP = 3'd0, PUSH = 3'd1, POP = 3'd2, WRT = 3'd3,
                         WRI = 3'd4, XCH = 3'd5, WRP = 3'd6, CHK = 3'd7;

  typedef struct {
    string       rq;
    logic        ca;
    logic [79:0] ea;
    logic        cb;
    logic [79:0] eb;
    logic [2:0]  et;
    logic        eo;
    logic        eu;
  } exp_t;

  logic        clk = 1'b0;
  logic        arst_n;
  logic [2:0]  op_i;
  logic [2:0]  idx_i;
  logic        bsel_i;
  logic [79:0] wdata_i;
  logic [79:0] opa_o, opb_o;
  logic [2:0]  top_o;
  logic        ovf_o, unf_o;

  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  stk_file uut (
    .clk     (clk),
    .arst_n  (arst_n),
    .op_i    (op_i),
    .idx_i   (idx_i),
    .bsel_i  (bsel_i),
    .wdata_i (wdata_i),
    .opa_o   (opa_o),
    .opb_o   (opb_o),
    .top_o   (top_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
  );

  function automatic logic [79:0] v(input int n);
    return 80'hC0DE_0000_0000_0000_0000 | 80'(n);
  endfunction

  task automatic drv(input logic [2:0] op, input logic [2:0] idx, input logic bs,
                     input logic [79:0] wd, input string rq,
                     input logic ca, input logic [79:0] ea,
                     input logic cb, input logic [79:0] eb,
                     input logic [2:0] et, input logic eo, input logic eu);
    exp_t it;
    @(negedge clk);
    op_i = op; idx_i = idx; bsel_i = bs; wdata_i = wd;
    it.rq = rq; it.ca = ca; it.ea = ea; it.cb = cb; it.eb = eb;
    it.et = et; it.eo = eo; it.eu = eu;
    sb_q.push_back(it);
  endtask

  // monitor: samples outputs 8 ns after the falling edge, before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (sb_q.size() != 0) begin
        exp_t it;
        it = sb_q.pop_front();
        total++;
        if ((it.ca && opa_o !== it.ea) || (it.cb && opb_o !== it.eb) ||
            top_o !== it.et || ovf_o !== it.eo || unf_o !== it.eu) begin
          bad++;
          $display("FAIL %s: opa=%h/%h opb=%h/%h top=%0d/%0d ovf=%b/%b unf=%b/%b (actual/expected)",
                   it.rq, opa_o, it.ea, opb_o, it.eb, top_o, it.et, ovf_o, it.eo, unf_o, it.eu);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; op_i = NOP; idx_i = '0; bsel_i = 1'b0; wdata_i = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    drv(NOP, 0, 0, 0, "R1 reset top", 0, 0, 0, 0, 3'd0, 0, 0);
    drv(CHK, 0, 0, 0, "R1 empty check", 0, 0, 0, 0, 3'd0, 0, 1);
    drv(POP, 0, 0, 0, "R6 pop empty", 0, 0, 0, 0, 3'd0, 0, 1);
    // R3 / R11: pushes wrap top from 0 to 7
    drv(PUSH, 0, 0, v(1), "R3 push1", 0, 0, 0, 0, 3'd0, 0, 0);
    drv(NOP, 0, 0, 0, "R11 wrap to 7", 1, v(1), 0, 0, 3'd7, 0, 0);
    drv(PUSH, 0, 0, v(2), "R3 push2", 0, 0, 0, 0, 3'd7, 0, 0);
    drv(PUSH, 0, 0, v(3), "R3 push3", 0, 0, 0, 0, 3'd6, 0, 0);
    // R7: implicit operands; R2: indexed operands
    drv(NOP, 0, 0, 0, "R7 st0 st1", 1, v(3), 1, v(2), 3'd5, 0, 0);
    drv(CHK, 2, 1, 0, "R2 st2", 1, v(3), 1, v(1), 3'd5, 0, 0);
    drv(NOP, 0, 1, 0, "R2 st0 by index", 1, v(3), 1, v(3), 3'd5, 0, 0);
    // R9: exchange st0 with st2
    drv(XCH, 2, 1, 0, "R9 exchange", 1, v(3), 1, v(1), 3'd5, 0, 0);
    drv(NOP, 2, 1, 0, "R9 swapped", 1, v(1), 1, v(3), 3'd5, 0, 0);
    // R8: write-backs
    drv(WRT, 0, 0, v(4), "R8 write top", 0, 0, 0, 0, 3'd5, 0, 0);
    drv(NOP, 0, 0, 0, "R8 top written", 1, v(4), 1, v(2), 3'd5, 0, 0);
    drv(WRI, 1, 1, v(5), "R8 write st1", 0, 0, 0, 0, 3'd5, 0, 0);
    drv(NOP, 0, 0, 0, "R8 st1 written", 1, v(4), 1, v(5), 3'd5, 0, 0);
    // R10: write st1 and pop
    drv(WRP, 0, 0, v(6), "R10 write-pop", 0, 0, 0, 0, 3'd5, 0, 0);
    drv(NOP, 0, 0, 0, "R10 result on top", 1, v(6), 1, v(3), 3'd6, 0, 0);
    // R4: pop
    drv(POP, 0, 0, 0, "R4 pop value", 1, v(6), 0, 0, 3'd6, 0, 0);
    drv(NOP, 0, 0, 0, "R4 top advanced", 1, v(3), 0, 0, 3'd7, 0, 0);
    // R6: faults on a one-entry stack change nothing
    drv(XCH, 1, 1, 0, "R6 exchange empty", 0, 0, 0, 0, 3'd7, 0, 1);
    drv(NOP, 0, 0, 0, "R6 after exchange", 1, v(3), 0, 0, 3'd7, 0, 0);
    drv(WRP, 0, 0, v(9), "R6 write-pop empty", 0, 0, 0, 0, 3'd7, 0, 1);
    drv(NOP, 0, 0, 0, "R6 after write-pop", 1, v(3), 0, 0, 3'd7, 0, 0);
    drv(POP, 0, 0, 0, "R4 last pop", 1, v(3), 0, 0, 3'd7, 0, 0);
    drv(CHK, 0, 0, 0, "R4 tag cleared", 0, 0, 0, 0, 3'd0, 0, 1);
    // R5: fill all eight, then overflow
    for (int k = 1; k <= 8; k++) begin
      drv(PUSH, 0, 0, v(16 + k), "R5 fill", 0, 0, 0, 0, 3'((8 - (k - 1)) % 8), 0, 0);
    end
    drv(PUSH, 0, 0, v(99), "R5 overflow", 1, v(24), 0, 0, 3'd0, 1, 0);
    drv(NOP, 7, 1, 0, "R5 unchanged st7", 1, v(24), 1, v(17), 3'd0, 0, 0);
    drv(CHK, 7, 1, 0, "R2 full check", 1, v(24), 1, v(17), 3'd0, 0, 0);
    drv(NOP, 0, 0, 0, "R7 full st1", 1, v(24), 1, v(23), 3'd0, 0, 0);

    @(negedge clk);
    op_i = NOP;
    wait (sb_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule